// File: doc/BRIEF.md
# Load-use stall unit for a five-stage pipeline

This block sits in the decode stage of a five-stage integer pipeline. It watches for one hazard: the instruction now in execute is a load, and the register that load writes is a source that the instruction in decode reads. That value only arrives from data memory one stage later. When the hazard is present, the unit freezes the program counter and the fetch/decode register for one cycle and sends an empty control bundle into the execute stage, so the dependent instruction waits there. On the next cycle the load has moved on, and the value can reach the dependent instruction through the normal forwarding path.

The fetch port carries no valid/ready handshake. The instruction word is taken as the memory contents at the address the block drives, and the only back-pressure is the stall itself, which holds that address. To make stall timing observable, the block contains a minimal model of the program counter, the fetch/decode register, the opcode decoder and the control and target-register fields of the decode/execute register. The decode stage supplies per-source "used" flags, because the operand fields alone do not say whether the instruction reads them. Forwarding and branch resolution are not part of this block.

Top module: `load_use_stall_top`

## Requirements
- R1: `stall` is high when the decode/execute memory-read bit is set and the decode/execute target field equals the fetch/decode rs field (bits 25:21) with `src_a_used` high, or equals the fetch/decode rt field (bits 20:16) with `src_b_used` high. It is low in every other case.
- R2: A match on a source whose used flag is low causes no stall.
- R3: While `stall` is high, `pc_we` and `ifid_we` are low. At the next edge the fetch address and `ifid_instr` keep their values.
- R4: The clock edge that ends a stall cycle loads all nine control bits of the decode/execute register with zero.
- R5: A stall never lasts two cycles in a row. In the cycle after it, the held instruction enters execute with its own decoded controls.
- R6: Without a stall, at each edge the fetch address grows by 4, `ifid_instr` takes `imem_data`, `idex_ctrl` takes the decode of the old `ifid_instr`, and `idex_rt` takes its bits 20:16.
- R7: A load whose target field is 0 never causes a stall.
- R8: `idex_ctrl` bit order, MSB first, is: destination-select, op-class high, op-class low, immediate-operand, branch, memory-read, memory-write, register-write, memory-to-register. The opcode is bits 31:26. Opcode 0x00 gives 110000010, 0x23 (load) gives 000101011, 0x2B (store) gives 000100100, 0x04 (branch-equal) gives 001010000. The all-zero word and any other opcode give all zeros.
- R9: While `rst_n` is low, the fetch address, `ifid_instr`, `idex_ctrl` and `idex_rt` are zero and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| src_a_used | input | 1 | Instruction in decode reads its rs field |
| src_b_used | input | 1 | Instruction in decode reads its rt field |
| ifid_instr | output | 32 | Contents of the fetch/decode register |
| idex_ctrl | output | 9 | Control bundle held in decode/execute |
| idex_rt | output | 5 | Target field held in decode/execute |
| pc_we | output | 1 | Program-counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| stall | output | 1 | Hazard found; a bubble is injected this cycle |

## Verification
The bench uses the default parameters: a 32-bit word, 5-bit register fields, a step of 4 and a reset address of 0. With these, a short program at address 0 can place each pairing directly behind a load: a dependent R-type instruction, a store that reads the loaded register through rt, a load that addresses through it, a branch-equal, a load whose rt is only written, and a load to register 0. A second pass over the same program, with both used flags held low, must show no bubbles at all.

// File: rtl/lus_pkg.sv
package lus_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 6'h04;

  // field order is the bit order seen on idex_ctrl, MSB first
  typedef struct packed {
    logic dst_sel;
    logic opc_hi;
    logic opc_lo;
    logic imm_op;
    logic br;
    logic mrd;
    logic mwr;
    logic rwr;
    logic m2r;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_NONE = '0;

endpackage

// File: rtl/lus_ctrl_decode.sv
module lus_ctrl_decode
  import lus_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  logic [OPC_W-1:0] opc;
  assign opc = instr[INSTR_W-1:OPC_LSB];

  always_comb begin
    ctrl = CTRL_NONE;
    if (instr != '0) begin
      unique case (opc)
        OPC_RTYPE: begin
          ctrl.dst_sel = 1'b1;
          ctrl.opc_hi  = 1'b1;
          ctrl.rwr     = 1'b1;
        end
        OPC_LOAD: begin
          ctrl.imm_op = 1'b1;
          ctrl.mrd    = 1'b1;
          ctrl.rwr    = 1'b1;
          ctrl.m2r    = 1'b1;
        end
        OPC_STORE: begin
          ctrl.imm_op = 1'b1;
          ctrl.mwr    = 1'b1;
        end
        OPC_BREQ: begin
          ctrl.opc_lo = 1'b1;
          ctrl.br     = 1'b1;
        end
        default: ctrl = CTRL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lus_hazard_unit.sv
module lus_hazard_unit #(
  parameter int REG_AW = 5,
  parameter int N_SRC  = 2
) (
  input  logic                          ex_mem_read,
  input  logic [REG_AW-1:0]             ex_rt,
  input  logic [N_SRC-1:0][REG_AW-1:0]  id_src,
  input  logic [N_SRC-1:0]              id_used,
  output logic                          hazard
);
  logic [N_SRC-1:0] hit;
  logic             ex_live;

  // register zero is never a real producer
  assign ex_live = ex_mem_read && (ex_rt != '0);

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      assign hit[g] = id_used[g] && (id_src[g] == ex_rt);
    end
  endgenerate

  assign hazard = ex_live && (|hit);
endmodule

// File: rtl/lus_pipe_regs.sv
module lus_pipe_regs
  import lus_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              INSTR_W  = 32,
  parameter int              REG_AW   = 5,
  parameter int              PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pc_we,
  input  logic               ifid_we,
  input  logic               bubble,
  input  logic [INSTR_W-1:0] fetch_word,
  input  ctrl_t              dec_ctrl,
  input  logic [REG_AW-1:0]  dec_rt,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] ifid,
  output ctrl_t              ex_ctrl,
  output logic [REG_AW-1:0]  ex_rt
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= RESET_PC;
    end else if (pc_we) begin
      pc <= pc + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifid <= '0;
    end else if (ifid_we) begin
      ifid <= fetch_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_ctrl <= CTRL_NONE;
      ex_rt   <= '0;
    end else begin
      ex_ctrl <= bubble ? CTRL_NONE : dec_ctrl;
      ex_rt   <= dec_rt;
    end
  end
endmodule

// File: rtl/load_use_stall_top.sv
module load_use_stall_top
  import lus_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              INSTR_W  = 32,
  parameter int              REG_AW   = 5,
  parameter int              PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  input  logic               src_a_used,
  input  logic               src_b_used,
  output logic [INSTR_W-1:0] ifid_instr,
  output logic [CTRL_W-1:0]  idex_ctrl,
  output logic [REG_AW-1:0]  idex_rt,
  output logic               pc_we,
  output logic               ifid_we,
  output logic               stall
);
  localparam int RS_MSB = INSTR_W - OPC_W - 1;
  localparam int RS_LSB = RS_MSB - REG_AW + 1;
  localparam int RT_MSB = RS_LSB - 1;
  localparam int RT_LSB = RT_MSB - REG_AW + 1;

  ctrl_t                     dec_ctrl;
  ctrl_t                     ex_ctrl;
  logic [1:0][REG_AW-1:0]    src_fields;
  logic [1:0]                src_used;
  logic                      hz;

  assign src_fields[0] = ifid_instr[RS_MSB:RS_LSB];
  assign src_fields[1] = ifid_instr[RT_MSB:RT_LSB];
  assign src_used      = {src_b_used, src_a_used};

  lus_ctrl_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr (ifid_instr),
    .ctrl  (dec_ctrl)
  );

  lus_hazard_unit #(.REG_AW(REG_AW), .N_SRC(2)) u_hz (
    .ex_mem_read (ex_ctrl.mrd),
    .ex_rt       (idex_rt),
    .id_src      (src_fields),
    .id_used     (src_used),
    .hazard      (hz)
  );

  lus_pipe_regs #(
    .PC_W(PC_W), .INSTR_W(INSTR_W), .REG_AW(REG_AW),
    .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .bubble     (hz),
    .fetch_word (imem_data),
    .dec_ctrl   (dec_ctrl),
    .dec_rt     (src_fields[1]),
    .pc         (imem_addr),
    .ifid       (ifid_instr),
    .ex_ctrl    (ex_ctrl),
    .ex_rt      (idex_rt)
  );

  assign pc_we     = !hz;
  assign ifid_we   = !hz;
  assign stall     = hz;
  assign idex_ctrl = ex_ctrl;
endmodule

// File: rtl/load_use_stall_chk.sv
module load_use_stall_chk #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int REG_AW  = 5,
  parameter int PC_STEP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PC_W-1:0]    imem_addr,
  input logic [INSTR_W-1:0] ifid_instr,
  input logic [8:0]         idex_ctrl,
  input logic [REG_AW-1:0]  idex_rt,
  input logic               stall
);
  localparam int MRD_BIT = 3;

  assert_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> idex_ctrl[MRD_BIT]);

  assert_no_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (idex_rt != '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (imem_addr == $past(imem_addr)) && (ifid_instr == $past(ifid_instr)));

  assert_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (idex_ctrl == '0));

  assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (imem_addr == $past(imem_addr) + PC_W'(PC_STEP)));
endmodule

bind load_use_stall_top load_use_stall_chk #(
  .PC_W(PC_W), .INSTR_W(INSTR_W), .REG_AW(REG_AW), .PC_STEP(PC_STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .ifid_instr (ifid_instr),
  .idex_ctrl  (idex_ctrl),
  .idex_rt    (idex_rt),
  .stall      (stall)
);

// File: tb/tb_load_use_stall_top.sv
module tb_load_use_stall_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, ifid_instr;
  logic        src_a_used, src_b_used;
  logic [8:0]  idex_ctrl;
  logic [4:0]  idex_rt;
  logic        pc_we, ifid_we, stall;

  int n_chk = 0;
  int n_fail = 0;
  bit mask_off = 1'b0;

  always #5 clk = ~clk;

  load_use_stall_top dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .src_a_used(src_a_used), .src_b_used(src_b_used), .ifid_instr(ifid_instr),
    .idex_ctrl(idex_ctrl), .idex_rt(idex_rt), .pc_we(pc_we), .ifid_we(ifid_we),
    .stall(stall)
  );

  function automatic logic [31:0] prog(input logic [31:0] a);
    case (a)
      32'd0:  return 32'h8C220014; // load r2
      32'd4:  return 32'h00452024; // rtype reads r2 via rs -> bubble
      32'd8:  return 32'h00822025; // reads r2, two behind the load
      32'd12: return 32'h8C230000; // load r3
      32'd16: return 32'h00C74820; // independent
      32'd20: return 32'h8C200004; // load r0
      32'd24: return 32'h00004020; // reads r0
      32'd28: return 32'h8C250000; // load r5
      32'd32: return 32'hAC250008; // store, rt=r5 -> bubble
      32'd36: return 32'h8C260000; // load r6
      32'd40: return 32'h8CC70000; // load addressed by r6 -> bubble
      32'd44: return 32'h01675020; // rt=r7 -> bubble
      32'd48: return 32'h8C2C0000; // load r12
      32'd52: return 32'h11800003; // branch-equal rs=r12 -> bubble
      32'd56: return 32'h8C2D0000; // load r13
      32'd60: return 32'h8C4D0000; // load, rt=r13 written only
      32'd64: return 32'h01A07820; // rs=r13 -> bubble
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [8:0] dec(input logic [31:0] w);
    if (w == 32'h0) return 9'b0;
    case (w[31:26])
      6'h00: return 9'b110000010;
      6'h23: return 9'b000101011;
      6'h2B: return 9'b000100100;
      6'h04: return 9'b001010000;
      default: return 9'b0;
    endcase
  endfunction

  function automatic bit uses_rs(input logic [31:0] w);
    if (w == 32'h0) return 1'b0;
    return (w[31:26] inside {6'h00, 6'h23, 6'h2B, 6'h04});
  endfunction

  function automatic bit uses_rt(input logic [31:0] w);
    if (w == 32'h0) return 1'b0;
    return (w[31:26] inside {6'h00, 6'h2B, 6'h04});
  endfunction

  assign imem_data  = prog(imem_addr);
  assign src_a_used = uses_rs(ifid_instr) && !mask_off;
  assign src_b_used = uses_rt(ifid_instr) && !mask_off;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference state
  logic [31:0] m_pc, m_ifid;
  logic [8:0]  m_ctrl;
  logic [4:0]  m_rt;
  int          obs_stalls;

  function automatic bit m_hazard();
    bit a, b;
    a = uses_rs(m_ifid) && !mask_off && (m_ifid[25:21] == m_rt);
    b = uses_rt(m_ifid) && !mask_off && (m_ifid[20:16] == m_rt);
    return m_ctrl[3] && (m_rt != 5'd0) && (a || b);
  endfunction

  task automatic m_advance();
    bit hz;
    hz = m_hazard();
    m_rt   = m_ifid[20:16];
    m_ctrl = hz ? 9'b0 : dec(m_ifid);
    if (!hz) begin
      m_ifid = prog(m_pc);
      m_pc   = m_pc + 32'd4;
    end
  endtask

  task automatic compare();
    bit hz;
    hz = m_hazard();
    chk(imem_addr == m_pc,     "R3/R6 fetch address", imem_addr, m_pc);
    chk(ifid_instr == m_ifid,  "R3/R6 ifid_instr", ifid_instr, m_ifid);
    chk(idex_ctrl == m_ctrl,   "R4/R8 idex_ctrl", idex_ctrl, m_ctrl);
    chk(idex_rt == m_rt,       "R6 idex_rt", idex_rt, m_rt);
    chk(stall == hz,           "R1/R2/R7 stall", stall, hz);
    chk(pc_we == !hz && ifid_we == !hz, "R3 enables", {pc_we, ifid_we}, {!hz, !hz});
    if (stall) obs_stalls++;
  endtask

  task automatic run_pass(input bit mask, input int exp_stalls);
    rst_n = 1'b0;
    mask_off = mask;
    repeat (3) @(negedge clk);
    chk(imem_addr == 32'h0 && ifid_instr == 32'h0, "R9 reset regs",
        {imem_addr, ifid_instr}, 64'h0);
    chk(idex_ctrl == 9'h0 && idex_rt == 5'h0 && !stall, "R9 reset ctrl",
        {idex_ctrl, idex_rt, stall}, 64'h0);
    m_pc = 32'h0; m_ifid = 32'h0; m_ctrl = 9'h0; m_rt = 5'h0;
    obs_stalls = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      m_advance();
      compare();
    end
    // R5 count of bubbles over the program: rs, store-rt, load-addr, rt, branch, rs-after-only-written
    chk(obs_stalls == exp_stalls, "R5 bubble total", obs_stalls, exp_stalls);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    run_pass(1'b0, 6);
    // R2: all used flags low, no bubbles anywhere
    run_pass(1'b1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule